// File: doc/BRIEF.md
# Register Access Width Adapter

This block sits between a processor bus and a register file whose registers do not all share one width. The bus may read or write 8, 16 or 32 bits at a time. Each register, though, accepts only its own native width. The adapter looks up the native width for the addressed 4-byte group. It then turns each bus access into one or more native-width accesses on a simple register-file port, using big-endian byte order throughout.

An access narrower than the register reads the whole register and picks out the addressed lanes. A narrow write becomes a read followed by a write of the merged value. An access wider than the register becomes a short run of native accesses at ascending addresses, and the lowest address carries the most significant part. The register-file port answers a read in the same cycle and takes at most one access per cycle. While a run is in progress the adapter holds `busy` high. When the run ends it pulses `done`, with the assembled read data, in the cycle after the last native access.

Top module: `reg_width_adapter`

## Requirements
- R1: Offsets of 0x200 and above are rejected: no native access is made, `done` pulses in the cycle after acceptance, and `rdata` is 0 for reads.
- R2: The native width of offset `o` is set by group `o[8:2]`. Groups 0-11 are byte-wide, 12-15 are 16-bit, 16-47 are 32-bit, 48-63 are 16-bit and 64-127 are byte-wide. Every native access carries this width on `nSize`.
- R3: An access whose size equals the native width makes exactly one native access at the same offset, with the same data.
- R4: A read narrower than the register makes one native read of the aligned register and returns the addressed lanes in big-endian order. A byte at offset ending 00 of a 32-bit register is bits 31:24. An even byte of a 16-bit register is bits 15:8. A 16-bit read at offset ending 00 of a 32-bit register is bits 31:16.
- R5: A read wider than the register makes size/native native reads at ascending addresses. The first result fills the most significant part of `rdata`.
- R6: A write narrower than the register reads the aligned register, replaces only the addressed bytes, and writes the whole register back at the same address in the next cycle.
- R7: A write wider than the register makes size/native native writes at ascending addresses. The first write carries the most significant part of `reqWdata`.
- R8: `busy` is high from the cycle after acceptance until the last native access. `reqValid` is ignored while `busy` is high. `done` is never high together with `busy`, and `rdata` is 0 after a write.
- R9: `reqSize` is encoded as 0 = byte, 1 = 16-bit, 2 = 32-bit, and 3 is treated as 32-bit. Offset bits below the access size are ignored. Native data is right-aligned on `nWdata` and `nRdata`. Every native address is aligned to its native width.
- R10: The native accesses of one request occupy consecutive cycles starting in the cycle after acceptance. `done` is seen steps+1 cycles after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Bus request present; accepted when not busy |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqSize | input | 2 | Access size code (R9) |
| reqAddr | input | 10 | Byte offset into the register window |
| reqWdata | input | 32 | Write data, right-aligned |
| busy | output | 1 | Native sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Assembled read data, valid with `done` |
| nValid | output | 1 | Native access strobe |
| nWrite | output | 1 | Native access is a write |
| nSize | output | 2 | Native access width code |
| nAddr | output | 10 | Native access offset |
| nWdata | output | 32 | Native write data, right-aligned |
| nRdata | input | 32 | Native read data, same cycle, right-aligned |

## Verification
Two things can fall in the same cycle: a new bus request can arrive while the adapter is still stepping through a multi-access run. The bench provokes this by raising `reqValid` with a byte write to a 32-bit register during the first busy cycle of a four-step split write. A later read of that register must return its old contents, and the number of native accesses counted for the split write must still be exactly four. This shows that the stray request neither started a sequence nor disturbed the one in progress.

// File: rtl/rwa_pkg.sv
package rwa_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } accSize_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       load;   // latch incoming request
    logic       empty;  // accepted request needs no native access
    logic       issue;  // drive a native access this cycle
    logic       last;   // this native access ends the run
    logic [1:0] step;   // index of the native access in the run
  } ctlStrobe_t;

  function automatic logic [2:0] sizeBytes(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/rwa_control.sv
module rwa_control
  import rwa_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [2:0] planSteps,
  output ctlStrobe_t stb,
  output logic       busy,
  output logic       done
);

  typedef enum logic {ST_IDLE, ST_RUN} state_t;

  state_t     state;
  logic [1:0] stepCnt;
  logic [2:0] total;

  always_comb begin
    stb.load  = (state == ST_IDLE) && reqValid;
    stb.empty = stb.load && (planSteps == 3'd0);
    stb.issue = (state == ST_RUN);
    stb.step  = stepCnt;
    stb.last  = (state == ST_RUN) && ({1'b0, stepCnt} == total - 3'd1);
  end

  assign busy = (state == ST_RUN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      total   <= '0;
      done    <= 1'b0;
    end else begin
      done <= stb.empty || stb.last;
      if (stb.load && !stb.empty) begin
        state   <= ST_RUN;
        stepCnt <= '0;
        total   <= planSteps;
      end else if (state == ST_RUN) begin
        if (stb.last) state <= ST_IDLE;
        else          stepCnt <= stepCnt + 2'd1;
      end
    end
  end

  // R1
  reject_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.empty |=> done && !busy);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

endmodule

// File: rtl/rwa_datapath.sv
module rwa_datapath
  import rwa_pkg::*;
#(
  parameter int OFFS_W   = 10,
  parameter int WINDOW   = 512,
  parameter int HALF_LO  = 12,
  parameter int WORD_LO  = 16,
  parameter int HALF2_LO = 48,
  parameter int BYTE2_LO = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        stb,
  input  logic              reqWrite,
  input  logic [1:0]        reqSize,
  input  logic [OFFS_W-1:0] reqAddr,
  input  logic [31:0]       reqWdata,
  output logic [2:0]        planSteps,
  output logic              nValid,
  output logic              nWrite,
  output logic [1:0]        nSize,
  output logic [OFFS_W-1:0] nAddr,
  output logic [31:0]       nWdata,
  input  logic [31:0]       nRdata,
  output logic [31:0]       rdata
);

  localparam int WIN_W = $clog2(WINDOW);
  localparam int GRP_W = WIN_W - 2;

  function automatic logic [1:0] mapWidth(input logic [GRP_W-1:0] grp);
    int g;
    g = int'(grp);
    if (g < HALF_LO)       return SZ_BYTE;
    else if (g < WORD_LO)  return SZ_HALF;
    else if (g < HALF2_LO) return SZ_WORD;
    else if (g < BYTE2_LO) return SZ_HALF;
    else                   return SZ_BYTE;
  endfunction

  function automatic logic [31:0] laneMask(input int bytes);
    return (bytes >= 4) ? 32'hFFFF_FFFF : ((32'd1 << (8 * bytes)) - 32'd1);
  endfunction

  // plan for the incoming request
  logic [1:0] inSz, inNat;
  logic       inRej;

  always_comb begin
    inSz  = (reqSize == 2'd3) ? SZ_WORD : reqSize;
    inRej = int'(reqAddr) >= WINDOW;
    inNat = mapWidth(reqAddr[WIN_W-1:2]);
    if (inRej)              planSteps = 3'd0;
    else if (inSz > inNat)  planSteps = 3'd1 << (inSz - inNat);
    else if (inSz == inNat) planSteps = 3'd1;
    else                    planSteps = reqWrite ? 3'd2 : 3'd1;
  end

  // latched request
  logic [OFFS_W-1:0] lOff;
  logic [1:0]        lSz, lNat;
  logic              lWrite, lNarrow, lRmw;
  logic [31:0]       lWdata, acc;

  // native access shaping
  int          nb, sb, lane, sh, subSh;
  logic [31:0] natMask, szMask, captured, accNext;
  logic [2:0]  natBytes;

  always_comb begin
    natBytes = sizeBytes(lNat);
    nb       = int'(natBytes);
    sb       = int'(sizeBytes(lSz));
    lane     = int'(lOff) & (nb - 1);
    sh       = lNarrow ? 8 * (nb - sb - lane) : 0;
    subSh    = lNarrow ? 0 : 8 * nb * ((sb / nb) - 1 - int'(stb.step));
    if (subSh < 0) subSh = 0;
    natMask  = laneMask(nb);
    szMask   = laneMask(sb);
    captured = nRdata & natMask;
    accNext  = (nb >= 4) ? captured : ((acc << (8 * nb)) | captured);

    nValid = stb.issue;
    nSize  = lNat;
    nWrite = lWrite && (!lRmw || (stb.step == 2'd1));
    if (lNarrow) nAddr = lOff & ~OFFS_W'(nb - 1);
    else         nAddr = lOff + OFFS_W'(int'(stb.step) * nb);
    if (lRmw) nWdata = (acc & ~(szMask << sh)) | ((lWdata & szMask) << sh);
    else      nWdata = (lWdata >> subSh) & natMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lOff    <= '0;
      lSz     <= SZ_BYTE;
      lNat    <= SZ_BYTE;
      lWrite  <= 1'b0;
      lNarrow <= 1'b0;
      lRmw    <= 1'b0;
      lWdata  <= '0;
      acc     <= '0;
      rdata   <= '0;
    end else begin
      if (stb.load) begin
        lOff    <= reqAddr & ~OFFS_W'(sizeBytes(inSz) - 3'd1);
        lSz     <= inSz;
        lNat    <= inNat;
        lWrite  <= reqWrite;
        lNarrow <= inSz < inNat;
        lRmw    <= (inSz < inNat) && reqWrite;
        lWdata  <= reqWdata;
        acc     <= '0;
        if (stb.empty) rdata <= '0;
      end
      if (stb.issue && !nWrite)
        acc <= lNarrow ? captured : accNext;
      if (stb.issue && stb.last) begin
        if (lWrite)       rdata <= '0;
        else if (lNarrow) rdata <= (captured >> sh) & szMask;
        else              rdata <= accNext;
      end
    end
  end

  // R1
  in_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    nValid |-> int'(nAddr) < WINDOW);

  // R9
  native_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    nValid |-> (nAddr & OFFS_W'(natBytes - 3'd1)) == '0);

  // R6
  rmw_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    nValid && lRmw && nWrite |-> $past(nValid) && !$past(nWrite) && nAddr == $past(nAddr));

  // R5
  ascend_chk: assert property (@(posedge clk) disable iff (!rstN)
    nValid && $past(nValid) && !lRmw |-> nAddr == $past(nAddr) + OFFS_W'(natBytes));

endmodule

// File: rtl/reg_width_adapter.sv
module reg_width_adapter
  import rwa_pkg::*;
#(
  parameter int OFFS_W   = 10,
  parameter int WINDOW   = 512,
  parameter int HALF_LO  = 12,
  parameter int WORD_LO  = 16,
  parameter int HALF2_LO = 48,
  parameter int BYTE2_LO = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [1:0]        reqSize,
  input  logic [OFFS_W-1:0] reqAddr,
  input  logic [31:0]       reqWdata,
  output logic              busy,
  output logic              done,
  output logic [31:0]       rdata,
  output logic              nValid,
  output logic              nWrite,
  output logic [1:0]        nSize,
  output logic [OFFS_W-1:0] nAddr,
  output logic [31:0]       nWdata,
  input  logic [31:0]       nRdata
);

  ctlStrobe_t stb;
  logic [2:0] planSteps;

  rwa_control u_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .planSteps(planSteps),
    .stb(stb), .busy(busy), .done(done)
  );

  rwa_datapath #(
    .OFFS_W(OFFS_W), .WINDOW(WINDOW), .HALF_LO(HALF_LO), .WORD_LO(WORD_LO),
    .HALF2_LO(HALF2_LO), .BYTE2_LO(BYTE2_LO)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqWrite(reqWrite), .reqSize(reqSize),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .planSteps(planSteps),
    .nValid(nValid), .nWrite(nWrite), .nSize(nSize), .nAddr(nAddr),
    .nWdata(nWdata), .nRdata(nRdata), .rdata(rdata)
  );

endmodule

// File: tb/reg_width_adapter_test.sv
`timescale 1ns/1ps
module reg_width_adapter_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [1:0]  reqSize = 2'd0;
  logic [9:0]  reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic        busy, done, nValid, nWrite;
  logic [1:0]  nSize;
  logic [9:0]  nAddr;
  logic [31:0] nWdata, nRdata, rdata;

  int checks = 0, errors = 0, nCount = 0;

  always #2 clk = ~clk;

  reg_width_adapter uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSize(reqSize), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .busy(busy), .done(done), .rdata(rdata), .nValid(nValid), .nWrite(nWrite),
    .nSize(nSize), .nAddr(nAddr), .nWdata(nWdata), .nRdata(nRdata)
  );

  // register file model: byte array, big-endian
  logic [7:0] mem [0:511];
  logic [7:0] refMem [0:511];

  always_comb begin
    case (nSize)
      2'd0:    nRdata = {24'd0, mem[nAddr[8:0]]};
      2'd1:    nRdata = {16'd0, mem[nAddr[8:0]], mem[nAddr[8:0] + 9'd1]};
      default: nRdata = {mem[nAddr[8:0]], mem[nAddr[8:0] + 9'd1],
                         mem[nAddr[8:0] + 9'd2], mem[nAddr[8:0] + 9'd3]};
    endcase
  end

  always @(posedge clk) begin
    if (nValid && nWrite) begin
      case (nSize)
        2'd0: mem[nAddr[8:0]] <= nWdata[7:0];
        2'd1: begin
          mem[nAddr[8:0]]        <= nWdata[15:8];
          mem[nAddr[8:0] + 9'd1] <= nWdata[7:0];
        end
        default: begin
          mem[nAddr[8:0]]        <= nWdata[31:24];
          mem[nAddr[8:0] + 9'd1] <= nWdata[23:16];
          mem[nAddr[8:0] + 9'd2] <= nWdata[15:8];
          mem[nAddr[8:0] + 9'd3] <= nWdata[7:0];
        end
      endcase
    end
  end

  function automatic int mapBytes(input int off);
    int g;
    g = off >> 2;
    if (g < 12) return 1;
    if (g < 16) return 2;
    if (g < 48) return 4;
    if (g < 64) return 2;
    return 1;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  typedef struct {
    logic        isRead;
    logic [31:0] exp;
    int          steps;
    string       tag;
  } item_t;
  item_t sb[$];

  // monitor
  always @(negedge clk) begin
    if (rstN && nValid) begin
      nCount++;
      check(int'(nSize) == $clog2(mapBytes(int'(nAddr))) && int'(nAddr) < 512,
            "R2 native width", 32'(nSize), 32'($clog2(mapBytes(int'(nAddr)))));
    end
    if (rstN && done) begin
      if (sb.size() == 0) begin
        check(1'b0, "R8 unexpected done", 32'd1, 32'd0);
      end else begin
        item_t it;
        it = sb.pop_front();
        check(rdata == it.exp, it.tag, rdata, it.exp);
        check(nCount == it.steps, {it.tag, " access count"}, 32'(nCount), 32'(it.steps));
      end
      nCount = 0;
    end
  end

  task automatic access(input logic wr, input logic [1:0] sz, input int addr,
                        input logic [31:0] wd, input string tag, input bit poke);
    int off, szN, sBytes, nBytes, steps, cnt;
    bit rej;
    item_t it;
    logic [31:0] e;
    off    = addr & 10'h3FF;
    szN    = (sz == 2'd3) ? 2 : int'(sz);
    sBytes = 1 << szN;
    off    = off & ~(sBytes - 1);
    rej    = off >= 512;
    nBytes = rej ? 1 : mapBytes(off);
    if (rej)                  steps = 0;
    else if (sBytes > nBytes) steps = sBytes / nBytes;
    else if (sBytes == nBytes) steps = 1;
    else                      steps = wr ? 2 : 1;
    e = '0;
    if (!rej) begin
      for (int i = 0; i < sBytes; i++) begin
        if (wr) refMem[off + i] = wd[8 * (sBytes - 1 - i) +: 8];
        else    e = (e << 8) | 32'(refMem[off + i]);
      end
    end
    it.isRead = !wr;
    it.exp    = wr ? 32'd0 : e;
    it.steps  = steps;
    it.tag    = tag;
    sb.push_back(it);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqSize = sz; reqAddr = 10'(addr); reqWdata = wd;
    @(negedge clk);
    reqValid = 1'b0;
    cnt = 1;
    if (steps > 0) check(busy == 1'b1, "R8 busy during run", 32'(busy), 32'd1);
    if (poke) begin
      reqValid = 1'b1; reqWrite = 1'b1; reqSize = 2'd0; reqAddr = 10'h040; reqWdata = 32'hFF;
    end
    while (!done && cnt < 20) begin
      @(negedge clk);
      reqValid = 1'b0;
      cnt++;
    end
    check(cnt == steps + 1, {"R10 latency ", tag}, 32'(cnt), 32'(steps + 1));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) begin mem[i] = 8'h00; refMem[i] = 8'h00; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done && !nValid && rdata == 0, "reset state", {busy, done, nValid}, 0);

    // R3 same width
    access(1, 2'd2, 'h040, 32'h11223344, "R3 word write", 0);
    access(0, 2'd2, 'h040, 0, "R3 word read", 0);
    // R4 narrow reads
    access(0, 2'd0, 'h040, 0, "R4 byte 0 of word", 0);
    access(0, 2'd0, 'h043, 0, "R4 byte 3 of word", 0);
    access(0, 2'd1, 'h040, 0, "R4 upper half", 0);
    access(0, 2'd1, 'h042, 0, "R4 lower half", 0);
    // R6 read-modify-write
    access(1, 2'd0, 'h041, 32'hAB, "R6 byte into word", 0);
    access(1, 2'd1, 'h042, 32'hBEEF, "R6 half into word", 0);
    access(0, 2'd2, 'h040, 0, "R6 word after merges", 0);
    access(1, 2'd1, 'h030, 32'h5566, "R3 half write", 0);
    access(0, 2'd0, 'h030, 0, "R4 even byte of half", 0);
    access(1, 2'd0, 'h031, 32'h77, "R6 byte into half", 0);
    access(0, 2'd1, 'h030, 0, "R6 half after merge", 0);
    // R7 / R5 splits, with a stray request during the run (R8)
    access(1, 2'd2, 'h100, 32'hCAFEF00D, "R7 word to bytes", 1);
    access(0, 2'd0, 'h040, 0, "R8 stray request ignored", 0);
    access(0, 2'd2, 'h100, 0, "R5 word from bytes", 0);
    access(0, 2'd1, 'h102, 0, "R5 half from bytes", 0);
    access(1, 2'd2, 'h0C4, 32'h0A0B0C0D, "R7 word to halves", 0);
    access(0, 2'd2, 'h0C4, 0, "R5 word from halves", 0);
    access(1, 2'd1, 'h00A, 32'h1357, "R7 half to bytes", 0);
    access(0, 2'd0, 'h00B, 0, "R5 byte check", 0);
    // R9 encodings and alignment
    access(0, 2'd1, 'h043, 0, "R9 low bits ignored", 0);
    access(0, 2'd3, 'h0C4, 0, "R9 size 3 as word", 0);
    // R1 rejection
    access(1, 2'd2, 'h200, 32'hDEADBEEF, "R1 write rejected", 0);
    access(0, 2'd2, 'h200, 0, "R1 read rejected", 0);
    access(0, 2'd2, 'h000, 0, "R1 no alias at base", 0);
    access(0, 2'd0, 'h3FF, 0, "R1 top offset", 0);

    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R8 all completions seen", 32'(sb.size()), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule